// File: doc/BRIEF.md
# Reset Source Controller with Stabilization Wait

This block gathers every reason a device may need to restart and turns them into one internal reset, `sys_rst`. The five reasons are power arrival, leaving hardware standby, a watchdog overflow, a low level on the external reset pin, and a software reset request. Each reason leaves a sticky flag in a cause register. Boot code reads that register to learn why the last restart happened. The read also clears the register.

Some causes need the oscillator to settle before the core may run again. Power arrival always waits a fixed count of oscillator cycles. Standby release and watchdog overflow wait for a count chosen by a two-bit clock-select field. Pin and software resets return at once, unless the device was stopped when they arrived. While reset is held from a heavy cause, the block asks the clock multiplexer to fall back to the main clock and asks the watchdog to stop. Throughout reset it keeps the external bus read and write strobes inactive.

The block does not contain the oscillator, the watchdog counter or the clock multiplexer. It only drives their control inputs.

Top module: `rstsrc_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` and `clk_wdt_revert` are 1, `cause_flags` is 5'b00001 (bit 0 = power-on) and `cs_sel` is 3. After `por_n` rises, `sys_rst` stays high for 2^POR_LOG2 + SYNC_STAGES - 1 falling-edge samples, whatever value `cs_sel` holds.
- R2: A one-cycle `sw_rst_req` pulse makes `sys_rst` high from the next rising edge. When `in_stop` is low, the reset lasts exactly one cycle. The pulse sets `cause_flags` bit 4, and `clk_wdt_revert` stays 0.
- R3: A one-cycle `wdt_ovf` pulse holds `sys_rst` high for 1 + 2^L cycles, where L is the wait exponent given by `cs_sel`. `clk_wdt_revert` is 1 during that reset, and the pulse sets `cause_flags` bit 2.
- R4: The wait exponent for `cs_sel` value v is L = WAIT_BASE_LOG2 + WAIT_STEP_LOG2*v, for v = 0..3. A `cs_wr` pulse loads `cs_wdata` into `cs_sel` only while `sys_rst` is low. While `sys_rst` is high, the write is ignored.
- R5: A low level on `ext_rst_n` holds `sys_rst` high from the (SYNC_STAGES+1)th rising edge onward. When the pin is released with `in_stop` low, `sys_rst` falls on the (SYNC_STAGES+1)th edge after release. The pin sets `cause_flags` bit 3, and `clk_wdt_revert` stays 0.
- R6: While `hstby_n` is low, `sys_rst` and `clk_wdt_revert` are high. After release, `cause_flags` bit 1 is set, and `sys_rst` falls on rising edge SYNC_STAGES + 2 + 2^L after release.
- R7: If `in_stop` is high when a pin or software reset arrives, the 2^L wait is applied after the request ends, and `clk_wdt_revert` stays 0.
- R8: Flags are sticky and accumulate across several resets. A `cause_rd` pulse clears all of them on the next rising edge.
- R9: While `sys_rst` is high, `bus_rd` and `bus_wr` are 0. While it is low, they follow `bus_rd_req` and `bus_wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| hstby_n | input | 1 | Hardware standby pin, low = standby |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| sw_rst_req | input | 1 | Software reset request pulse |
| in_stop | input | 1 | Device is in stop mode |
| cs_wr | input | 1 | Write strobe for the clock-select field |
| cs_wdata | input | 2 | Clock-select write data |
| cause_rd | input | 1 | Read strobe for the cause flags (clears them) |
| bus_rd_req | input | 1 | Core read strobe |
| bus_wr_req | input | 1 | Core write strobe |
| sys_rst | output | 1 | Internal reset, active high |
| cause_flags | output | 5 | Sticky cause flags {sw, ext, wdt, standby, power-on} |
| cs_sel | output | 2 | Current clock-select field |
| clk_wdt_revert | output | 1 | Request main clock and watchdog stop |
| bus_rd | output | 1 | Gated external read strobe |
| bus_wr | output | 1 | Gated external write strobe |

## Verification
Watchdog and software pulses are swept over every clock-select value, both with and without stop mode. The measured reset length then tells apart a fixed one-cycle reset, a stop-forced wait and each of the four wait lengths. Pin and standby resets are held for several cycles and then released. Their release edges show the synchronizer latency, and they show whether the wait follows a level cause. Power-on is timed against its fixed count while the select field holds 3, to show that the select field does not change it. Back-to-back causes without a read show flag accumulation, and a select write during reset shows that the write is ignored.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;
   localparam int unsigned NCAUSE = 5;
   localparam int unsigned C_POR   = 0;
   localparam int unsigned C_HSTBY = 1;
   localparam int unsigned C_WDT   = 2;
   localparam int unsigned C_EXT   = 3;
   localparam int unsigned C_SW    = 4;
   localparam int unsigned CS_W    = 2;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HOLD = 2'd1,
      ST_WAIT = 2'd2
   } rst_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rstsrc_sync.sv
module rstsrc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh[0] <= RST_VAL;
            else         sh[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh[i] <= RST_VAL;
            else         sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/rstsrc_waitctr.sv
module rstsrc_waitctr #(
   parameter int unsigned CW  = 18,
   parameter int unsigned LGW = 5
) (
   input  logic           clk,
   input  logic           arst_n,
   input  logic           clear,
   input  logic           en,
   input  logic [LGW-1:0] lg,
   output logic           done
);
   logic [CW-1:0] cnt;
   logic [CW:0]   lim;

   always_comb lim = ((CW+1)'(1) << lg) - (CW+1)'(1);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    cnt <= '0;
      else if (clear) cnt <= '0;
      else if (en)    cnt <= cnt + 1'b1;
   end

   assign done = ({1'b0, cnt} == lim);
endmodule

// File: rtl/rstsrc_flags.sv
module rstsrc_flags #(
   parameter int unsigned      N       = 5,
   parameter logic [N-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= RST_VAL;
      else         q <= (clr ? '0 : q) | set;
   end
endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
   import rstsrc_pkg::*;
#(
   parameter int unsigned POR_LOG2       = 18,
   parameter int unsigned WAIT_BASE_LOG2 = 12,
   parameter int unsigned WAIT_STEP_LOG2 = 2,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        hstby_n,
   input  logic        ext_rst_n,
   input  logic        wdt_ovf,
   input  logic        sw_rst_req,
   input  logic        in_stop,
   input  logic        cs_wr,
   input  logic [1:0]  cs_wdata,
   input  logic        cause_rd,
   input  logic        bus_rd_req,
   input  logic        bus_wr_req,
   output logic        sys_rst,
   output logic [4:0]  cause_flags,
   output logic [1:0]  cs_sel,
   output logic        clk_wdt_revert,
   output logic        bus_rd,
   output logic        bus_wr
);
   localparam int unsigned SEL_MAX_LOG2 = WAIT_BASE_LOG2 + WAIT_STEP_LOG2 * 3;
   localparam int unsigned CW  = max2(POR_LOG2, SEL_MAX_LOG2);
   localparam int unsigned LGW = $clog2(CW + 1);
   localparam logic [NCAUSE-1:0] FLAG_POR = NCAUSE'(1) << C_POR;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (POR_LOG2 < 1 || POR_LOG2 > 30) begin : g_bad_por
      $error("POR_LOG2 out of range 1..30");
   end
   if (WAIT_BASE_LOG2 < 1 || SEL_MAX_LOG2 > 30) begin : g_bad_sel
      $error("selectable wait exponents out of range 1..30");
   end

   // reset release synchronizer: asynchronous assert, clocked deassert
   logic rst_n_i;
   rstsrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
      .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n_i)
   );

   logic ext_s, hs_s;
   rstsrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
      .clk(clk), .arst_n(rst_n_i), .d(ext_rst_n), .q(ext_s)
   );
   rstsrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
      .clk(clk), .arst_n(rst_n_i), .d(hstby_n), .q(hs_s)
   );

   logic hs_prev;
   always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) hs_prev <= 1'b1;
      else          hs_prev <= hs_s;
   end

   logic ext_low, hs_low, hs_rel, level_act, pulse_act, trig;
   logic new_heavy, new_wait;
   always_comb begin
      ext_low   = ~ext_s;
      hs_low    = ~hs_s;
      hs_rel    = hs_s & ~hs_prev;
      level_act = ext_low | hs_low;
      pulse_act = wdt_ovf | sw_rst_req | hs_rel;
      trig      = level_act | pulse_act;
      new_heavy = wdt_ovf | hs_rel | hs_low;
      new_wait  = new_heavy | in_stop;
   end

   // state registers
   rst_state_e state_q, state_d;
   logic rst_q, rst_d, heavy_q, heavy_d, wait_q, wait_d, por_q, por_d;
   logic [1:0] cs_q;
   logic ctr_clr, ctr_en, ctr_done;
   logic [LGW-1:0] lg_sel;

   always_comb begin
      if (por_q) lg_sel = LGW'(POR_LOG2);
      else       lg_sel = LGW'(WAIT_BASE_LOG2 + WAIT_STEP_LOG2 * int'(cs_q));
   end

   always_comb begin
      state_d = state_q;
      rst_d   = rst_q;
      heavy_d = heavy_q;
      wait_d  = wait_q;
      por_d   = por_q;
      ctr_clr = 1'b0;
      ctr_en  = 1'b0;
      if (trig) begin
         state_d = ST_HOLD;
         rst_d   = 1'b1;
         if (state_q == ST_RUN) begin
            heavy_d = new_heavy;
            wait_d  = new_wait;
            por_d   = 1'b0;
         end else begin
            heavy_d = heavy_q | new_heavy;
            wait_d  = wait_q | new_wait;
         end
      end else begin
         unique case (state_q)
            ST_HOLD: begin
               if (wait_q) begin
                  state_d = ST_WAIT;
                  ctr_clr = 1'b1;
               end else begin
                  state_d = ST_RUN;
                  rst_d   = 1'b0;
               end
            end
            ST_WAIT: begin
               if (ctr_done) begin
                  state_d = ST_RUN;
                  rst_d   = 1'b0;
               end else begin
                  ctr_en = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q <= ST_WAIT;
         rst_q   <= 1'b1;
         heavy_q <= 1'b1;
         wait_q  <= 1'b1;
         por_q   <= 1'b1;
      end else begin
         state_q <= state_d;
         rst_q   <= rst_d;
         heavy_q <= heavy_d;
         wait_q  <= wait_d;
         por_q   <= por_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i)             cs_q <= 2'd3;
      else if (cs_wr && !rst_q) cs_q <= cs_wdata;
   end

   rstsrc_waitctr #(.CW(CW), .LGW(LGW)) u_ctr (
      .clk(clk), .arst_n(rst_n_i), .clear(ctr_clr), .en(ctr_en),
      .lg(lg_sel), .done(ctr_done)
   );

   logic [NCAUSE-1:0] flag_set;
   always_comb begin
      flag_set          = '0;
      flag_set[C_HSTBY] = hs_rel;
      flag_set[C_WDT]   = wdt_ovf;
      flag_set[C_EXT]   = ext_low;
      flag_set[C_SW]    = sw_rst_req;
   end

   rstsrc_flags #(.N(NCAUSE), .RST_VAL(FLAG_POR)) u_flags (
      .clk(clk), .arst_n(rst_n_i), .set(flag_set), .clr(cause_rd),
      .q(cause_flags)
   );

   assign sys_rst        = rst_q;
   assign cs_sel         = cs_q;
   assign clk_wdt_revert = rst_q & heavy_q;
   assign bus_rd         = bus_rd_req & ~rst_q;
   assign bus_wr         = bus_wr_req & ~rst_q;
endmodule

// File: rtl/rstsrc_ctrl_chk.sv
module rstsrc_ctrl_chk (
   input logic       clk,
   input logic       por_n,
   input logic       hstby_n,
   input logic       ext_rst_n,
   input logic       wdt_ovf,
   input logic       sw_rst_req,
   input logic       in_stop,
   input logic       cs_wr,
   input logic [1:0] cs_wdata,
   input logic       cause_rd,
   input logic       bus_rd_req,
   input logic       bus_wr_req,
   input logic       sys_rst,
   input logic [4:0] cause_flags,
   input logic [1:0] cs_sel,
   input logic       clk_wdt_revert,
   input logic       bus_rd,
   input logic       bus_wr
);
   a_r9_strobes_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd || bus_wr) |-> !sys_rst);

   a_r2_sw_enters: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst && sw_rst_req) |=> sys_rst);

   a_r3_wdt_revert: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst && wdt_ovf) |=> (sys_rst && clk_wdt_revert));

   a_r4_cs_frozen: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst |=> $stable(cs_sel));

   a_r8_sw_flag_source: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cause_flags[4]) |-> $past(sw_rst_req));

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!por_n)
      (cause_rd && !wdt_ovf) |=> !cause_flags[2]);

   a_r1_revert_in_rst: assert property (@(posedge clk) disable iff (!por_n)
      clk_wdt_revert |-> sys_rst);
endmodule

bind rstsrc_ctrl rstsrc_ctrl_chk u_chk (.*);

// File: tb/rstsrc_ctrl_tb.sv
module rstsrc_ctrl_tb;
   localparam int unsigned PL = 8;
   localparam int unsigned BL = 3;
   localparam int unsigned SL = 1;
   localparam int unsigned SS = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n = 1'b0, hstby_n = 1'b1, ext_rst_n = 1'b1, wdt_ovf = 1'b0;
   logic sw_rst_req = 1'b0, in_stop = 1'b0, cs_wr = 1'b0, cause_rd = 1'b0;
   logic [1:0] cs_wdata = 2'd0;
   logic bus_rd_req = 1'b0, bus_wr_req = 1'b0;
   logic sys_rst, clk_wdt_revert, bus_rd, bus_wr;
   logic [4:0] cause_flags;
   logic [1:0] cs_sel;

   rstsrc_ctrl #(.POR_LOG2(PL), .WAIT_BASE_LOG2(BL), .WAIT_STEP_LOG2(SL),
                 .SYNC_STAGES(SS)) u_dut (.*);

   int total = 0, bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int wlen(input int cs);
      return 1 << (BL + SL * cs);
   endfunction

   task automatic set_cs(input logic [1:0] v);
      @(negedge clk); cs_wdata = v; cs_wr = 1'b1;
      @(negedge clk); cs_wr = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); cause_rd = 1'b1;
      @(negedge clk); cause_rd = 1'b0;
   endtask

   // count negedge samples of sys_rst high after a one-cycle pulse
   task automatic pulse_len(input bit use_wdt, output int len, output int rev);
      @(negedge clk);
      if (use_wdt) wdt_ovf = 1'b1; else sw_rst_req = 1'b1;
      @(negedge clk);
      wdt_ovf = 1'b0; sw_rst_req = 1'b0;
      rev = int'(clk_wdt_revert);
      len = 0;
      while (sys_rst && len < 2000) begin
         len++;
         @(negedge clk);
      end
   endtask

   typedef struct packed {
      logic       wdt;
      logic [1:0] cs;
      logic       stop;
      logic [7:0] len;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b1, 2'd0, 1'b0, 8'd9},
      '{1'b1, 2'd1, 1'b0, 8'd17},
      '{1'b1, 2'd2, 1'b0, 8'd33},
      '{1'b1, 2'd3, 1'b0, 8'd65},
      '{1'b0, 2'd2, 1'b0, 8'd1},
      '{1'b0, 2'd1, 1'b1, 8'd17},
      '{1'b1, 2'd0, 1'b1, 8'd9},
      '{1'b0, 2'd3, 1'b1, 8'd65}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int len, rev;
      // R1 reset state, R9 strobes gated
      bus_rd_req = 1'b1; bus_wr_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 sys_rst during por", int'(sys_rst), 1);
      chk("R1 flags during por", int'(cause_flags), 1);
      chk("R1 cs during por", int'(cs_sel), 3);
      chk("R1 revert during por", int'(clk_wdt_revert), 1);
      chk("R9 bus_rd in reset", int'(bus_rd), 0);
      chk("R9 bus_wr in reset", int'(bus_wr), 0);
      por_n = 1'b1;
      len = 0;
      @(negedge clk);
      while (sys_rst && len < 5000) begin len++; @(negedge clk); end
      chk("R1 por wait length", len, (1 << PL) + SS - 1);
      chk("R9 bus_rd running", int'(bus_rd), 1);
      chk("R9 bus_wr running", int'(bus_wr), 1);
      bus_rd_req = 1'b0; bus_wr_req = 1'b0;

      // table: R2 R3 R4 R7 R8
      foreach (VEC[i]) begin
         in_stop = VEC[i].stop;
         set_cs(VEC[i].cs);
         chk("R4 cs written", int'(cs_sel), int'(VEC[i].cs));
         clear_flags();
         chk("R8 flags cleared", int'(cause_flags), 0);
         pulse_len(VEC[i].wdt, len, rev);
         chk(VEC[i].wdt ? "R3 wdt length" : (VEC[i].stop ? "R7 sw stop length" : "R2 sw length"),
             len, int'(VEC[i].len));
         chk(VEC[i].wdt ? "R3 revert" : "R7 no revert", rev, int'(VEC[i].wdt));
         chk(VEC[i].wdt ? "R3 flag" : "R2 flag", int'(cause_flags), VEC[i].wdt ? 4 : 16);
         in_stop = 1'b0;
      end

      // R8 accumulate without read
      clear_flags();
      pulse_len(1'b0, len, rev);
      pulse_len(1'b1, len, rev);
      chk("R8 accumulate", int'(cause_flags), 20);

      // R4 write ignored during reset
      set_cs(2'd3);
      @(negedge clk); wdt_ovf = 1'b1;
      @(negedge clk); wdt_ovf = 1'b0; cs_wdata = 2'd0; cs_wr = 1'b1;
      @(negedge clk); cs_wr = 1'b0;
      while (sys_rst) @(negedge clk);
      chk("R4 write ignored in reset", int'(cs_sel), 3);

      // R5 external pin, no stop
      set_cs(2'd0);
      clear_flags();
      @(negedge clk); ext_rst_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5 pin holds reset", int'(sys_rst), 1);
      chk("R5 pin no revert", int'(clk_wdt_revert), 0);
      chk("R5 pin flag", int'(cause_flags), 8);
      ext_rst_n = 1'b1;
      repeat (SS) @(negedge clk);
      chk("R5 still held before release edge", int'(sys_rst), 1);
      @(negedge clk);
      chk("R5 released", int'(sys_rst), 0);

      // R7 external pin in stop mode
      in_stop = 1'b1;
      @(negedge clk); ext_rst_n = 1'b0;
      repeat (6) @(negedge clk);
      in_stop = 1'b0; ext_rst_n = 1'b1;
      repeat (SS + wlen(0)) @(negedge clk);
      chk("R7 pin stop still waiting", int'(sys_rst), 1);
      @(negedge clk);
      chk("R7 pin stop released", int'(sys_rst), 0);

      // R6 hardware standby
      clear_flags();
      @(negedge clk); hstby_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 standby holds", int'(sys_rst), 1);
      chk("R6 standby revert", int'(clk_wdt_revert), 1);
      hstby_n = 1'b1;
      repeat (SS + 1 + wlen(0)) @(negedge clk);
      chk("R6 standby still waiting", int'(sys_rst), 1);
      @(negedge clk);
      chk("R6 standby released", int'(sys_rst), 0);
      chk("R6 standby flag", int'(cause_flags), 2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule